// File: doc/BRIEF.md
# Serial-In Latched Parallel-Out Register

This block takes a serial bit stream into a shift stage and presents it on parallel lines through a second, separate storage stage. Data moves into the shift stage one bit per rising edge of a shift strobe. A rising edge of a separate storage strobe then copies the whole shift stage into the storage stage in one step. The parallel outputs show only the storage stage, so they stay steady while a new word is shifted in and change together when the storage strobe arrives.

Both strobes, the serial data, an active-low output enable and an active-low shift-stage clear arrive as plain level inputs. A multi-flop synchroniser brings them into the single system clock domain, and the block detects edges by comparing each synchronised level with its value from the previous system clock. The parallel lines carry a per-line drive-enable that models a tri-state output. A cascade output carries the last shift-stage bit so that several units can be chained. Both strobes can stop indefinitely, and all state then holds.

Top module: `sipo_latch_reg`

## Requirements
- R1: On each detected rising edge of `shiftClk`, the shift stage moves one position toward bit WIDTH-1, and the synchronised `serIn` value enters bit 0.
- R2: On each detected rising edge of `storeClk`, the storage stage takes the entire shift stage in one cycle, and `parOut` presents the storage stage.
- R3: Without a `storeClk` rising edge, `parOut` does not change, whatever happens in the shift stage.
- R4: While `outEnN` is high, every bit of `parDrvEn` is 0 (lines released). While it is low, every bit is 1.
- R5: While neither strobe rises and `clearN` stays high, the shift stage, `parOut` and `cascadeOut` all hold their values for any length of time.
- R6: Only a low-to-high change counts as an edge. A strobe held high for many cycles gives exactly one action, and a falling change gives none.
- R7: `cascadeOut` equals the last shift-stage bit (bit WIDTH-1), so after WIDTH shifts it carries the first bit shifted in.
- R8: While `clearN` is low, the shift stage is forced to zero. The storage stage and `parOut` keep their values until the next storage edge.
- R9: When both strobes rise in the same system cycle, the storage stage takes the shift-stage value from before that cycle's shift.
- R10: While `rstN` is low and just after it is released, `parOut` and `cascadeOut` are 0 and `parDrvEn` is all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| serIn | input | 1 | Serial data bit |
| shiftClk | input | 1 | Shift strobe, acts on its rising edge |
| storeClk | input | 1 | Storage strobe, acts on its rising edge |
| outEnN | input | 1 | Output enable, active low |
| clearN | input | 1 | Shift-stage clear, active low |
| parOut | output | WIDTH | Parallel data from the storage stage |
| parDrvEn | output | WIDTH | Per-line drive enable (0 means high impedance) |
| cascadeOut | output | 1 | Last shift-stage bit, for chaining |

## Verification
The assertions check on every cycle that a shift strobe moves the shift stage by one with the new bit at the bottom. They also check that a clear empties it, that it holds when no strobe or clear is present, and that a detected edge never lasts two cycles. For the outputs, they check that `parOut` changes only after a storage strobe and that, when it does, it takes the shift stage from before that cycle, including when both strobes coincide. The bench alone shows the end-to-end behaviour at the ports: a full word shifted in and presented, a strobe held high or dropped, a long idle period, the output enable toggling, and the cascade bit after a complete word, all compared against a reference model under random sequences of operations.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  // Per-cycle actions that control hands to the datapath
  typedef struct packed {
    logic shift;   // shift-stage advance
    logic store;   // storage-stage load
    logic clear;   // shift-stage clear level
    logic serBit;  // synchronised serial data bit
  } strobe_t;
endpackage

// File: rtl/sipo_ctrl.sv
module sipo_ctrl
  import sipo_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serIn,
  input  logic    shiftClk,
  input  logic    storeClk,
  input  logic    outEnN,
  input  logic    clearN,
  output strobe_t stb,
  output logic    driveOn
);
  // Order of fields: {clearN, outEnN, storeClk, shiftClk, serIn}
  localparam int NSIG = 5;
  localparam logic [NSIG-1:0] IDLE_LEVELS = 5'b11000;
  localparam int TOP = SYNC_STAGES - 1;

  logic [NSIG-1:0] rawIn;
  logic [SYNC_STAGES-1:0][NSIG-1:0] syncChain;
  logic [NSIG-1:0] syncOut;
  logic prevShift;
  logic prevStore;

  assign rawIn = {clearN, outEnN, storeClk, shiftClk, serIn};

  generate
    if (SYNC_STAGES < 2) begin : g_badParam
      initial $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= {SYNC_STAGES{IDLE_LEVELS}};
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], rawIn};
    end
  end

  assign syncOut = syncChain[TOP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevShift <= 1'b0;
      prevStore <= 1'b0;
    end else begin
      prevShift <= syncOut[1];
      prevStore <= syncOut[2];
    end
  end

  always_comb begin
    stb.serBit = syncOut[0];
    stb.shift  = syncOut[1] & ~prevShift;
    stb.store  = syncOut[2] & ~prevStore;
    stb.clear  = ~syncOut[4];
    driveOn    = ~syncOut[3];
  end
endmodule

// File: rtl/sipo_datapath.sv
module sipo_datapath
  import sipo_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic             driveOn,
  output logic [WIDTH-1:0] shiftQ,
  output logic [WIDTH-1:0] parOut,
  output logic [WIDTH-1:0] parDrvEn,
  output logic             cascadeOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] storeQ;

  // Shift stage: clear dominates, then advance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (stb.clear) begin
      shiftQ <= '0;
    end else if (stb.shift) begin
      shiftQ <= {shiftQ[MSB-1:0], stb.serBit};
    end
  end

  // Storage stage samples the pre-shift value on a coincident edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeQ <= '0;
    end else if (stb.store) begin
      storeQ <= shiftQ;
    end
  end

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_line
      assign parOut[i]   = storeQ[i];
      assign parDrvEn[i] = driveOn;
    end
  endgenerate

  assign cascadeOut = shiftQ[MSB];
endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg
  import sipo_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic             shiftClk,
  input  logic             storeClk,
  input  logic             outEnN,
  input  logic             clearN,
  output logic [WIDTH-1:0] parOut,
  output logic [WIDTH-1:0] parDrvEn,
  output logic             cascadeOut
);
  strobe_t          stb;
  logic             driveOn;
  logic [WIDTH-1:0] shiftQ;

  sipo_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .serIn   (serIn),
    .shiftClk(shiftClk),
    .storeClk(storeClk),
    .outEnN  (outEnN),
    .clearN  (clearN),
    .stb     (stb),
    .driveOn (driveOn)
  );

  sipo_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .driveOn   (driveOn),
    .shiftQ    (shiftQ),
    .parOut    (parOut),
    .parDrvEn  (parDrvEn),
    .cascadeOut(cascadeOut)
  );
endmodule

// File: rtl/sipo_checker.sv
module sipo_checker
  import sipo_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input strobe_t          stb,
  input logic [WIDTH-1:0] shiftQ,
  input logic [WIDTH-1:0] parOut
);
  assert_shift_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shift && !stb.clear) |=> shiftQ == {$past(shiftQ[WIDTH-2:0]), $past(stb.serBit)});

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.store |=> parOut == $past(shiftQ));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.store |=> $stable(parOut));

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.shift && !stb.clear) |=> $stable(shiftQ));

  assert_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |=> !stb.shift);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> shiftQ == '0);

  assert_both_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.store && stb.shift) |=> parOut == $past(shiftQ));
endmodule

bind sipo_latch_reg sipo_checker #(.WIDTH(WIDTH)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .stb   (stb),
  .shiftQ(shiftQ),
  .parOut(parOut)
);

// File: tb/test_sipo_latch_reg.sv
module test_sipo_latch_reg;
  localparam int W = 8;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0;
  logic shiftClk = 1'b0;
  logic storeClk = 1'b0;
  logic outEnN = 1'b1;
  logic clearN = 1'b1;
  logic [W-1:0] parOut;
  logic [W-1:0] parDrvEn;
  logic cascadeOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] refShift = '0;
  logic [W-1:0] refStore = '0;

  always #2 clk = ~clk;

  sipo_latch_reg #(.WIDTH(W), .SYNC_STAGES(2)) i_sipo_latch_reg (
    .clk(clk), .rstN(rstN), .serIn(serIn), .shiftClk(shiftClk),
    .storeClk(storeClk), .outEnN(outEnN), .clearN(clearN),
    .parOut(parOut), .parDrvEn(parDrvEn), .cascadeOut(cascadeOut)
  );

  function automatic logic [W-1:0] nextShift(logic [W-1:0] s, logic b);
    return {s[W-2:0], b};
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doShift(logic b);
    serIn = b; shiftClk = 1'b1; waitCyc(SETTLE);
    shiftClk = 1'b0; waitCyc(SETTLE);
    refShift = nextShift(refShift, b);
  endtask

  task automatic doStore();
    storeClk = 1'b1; waitCyc(SETTLE);
    storeClk = 1'b0; waitCyc(SETTLE);
    refStore = refShift;
  endtask

  task automatic doBoth(logic b);
    serIn = b; shiftClk = 1'b1; storeClk = 1'b1; waitCyc(SETTLE);
    shiftClk = 1'b0; storeClk = 1'b0; waitCyc(SETTLE);
    refStore = refShift;
    refShift = nextShift(refShift, b);
  endtask

  task automatic doClear();
    clearN = 1'b0; waitCyc(SETTLE);
    clearN = 1'b1; waitCyc(SETTLE);
    refShift = '0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] word;
    logic [W-1:0] held;
    void'($urandom(32'd20240611));
    waitCyc(3);
    // R10: reset values during and after reset
    chk("R10 parOut in reset", parOut, '0);
    chk("R10 drive in reset", parDrvEn, '0);
    rstN = 1'b1;
    waitCyc(SETTLE);
    chk("R10 parOut after reset", parOut, '0);
    chk("R10 cascade after reset", {7'b0, cascadeOut}, '0);
    chk("R10 drive after reset", parDrvEn, '0);

    // R4: output enable
    outEnN = 1'b0; waitCyc(SETTLE);
    chk("R4 enabled drive", parDrvEn, '1);

    // R1/R2/R3/R7: shift a full word, outputs steady until store
    word = 8'hB4;
    for (int i = W - 1; i >= 0; i--) begin
      doShift(word[i]);
      chk("R3 parOut steady while shifting", parOut, refStore);
    end
    chk("R7 cascade is first bit", {7'b0, cascadeOut}, {7'b0, word[W-1]});
    doStore();
    chk("R1 R2 word presented", parOut, word);

    // R6: strobe held high long gives one shift; falling gives none
    serIn = 1'b1; shiftClk = 1'b1; waitCyc(20);
    refShift = nextShift(refShift, 1'b1);
    serIn = 1'b0; shiftClk = 1'b0; waitCyc(20);
    doStore();
    chk("R6 single action per rising edge", parOut, refShift);
    chk("R6 expected value", parOut, 8'h69);

    // R5: long idle holds everything
    held = parOut;
    waitCyc(60);
    chk("R5 parOut idle", parOut, held);
    chk("R5 cascade idle", {7'b0, cascadeOut}, {7'b0, refShift[W-1]});
    doStore();
    chk("R5 shift stage idle", parOut, held);

    // R8: clear empties shift only
    doClear();
    chk("R8 storage kept", parOut, held);
    chk("R8 cascade zero", {7'b0, cascadeOut}, '0);
    doStore();
    chk("R8 cleared stage stored", parOut, '0);

    // R9: coincident strobes
    for (int i = 0; i < W; i++) doShift(i[0]);
    doBoth(1'b1);
    chk("R9 pre-shift value stored", parOut, 8'h55);
    doStore();
    chk("R9 shift still applied", parOut, 8'hAB);

    // R4: release and re-enable, data unaffected
    outEnN = 1'b1; waitCyc(SETTLE);
    chk("R4 released drive", parDrvEn, '0);
    chk("R4 data kept while released", parOut, 8'hAB);
    outEnN = 1'b0; waitCyc(SETTLE);
    chk("R4 re-enabled drive", parDrvEn, '1);

    // Random mix of operations against the model
    for (int n = 0; n < 300; n++) begin
      int op;
      logic b;
      op = int'($urandom_range(0, 9));
      b = 1'($urandom_range(0, 1));
      if (op < 6) begin
        doShift(b);
        chk("R3 random shift keeps parOut", parOut, refStore);
      end else if (op < 8) begin
        doStore();
        chk("R2 random store", parOut, refStore);
      end else if (op == 8) begin
        doBoth(b);
        chk("R9 random coincident", parOut, refStore);
      end else begin
        doClear();
        chk("R8 random clear", parOut, refStore);
      end
      chk("R7 random cascade", {7'b0, cascadeOut}, {7'b0, refShift[W-1]});
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule